// File: doc/BRIEF.md
# Prioritised Interrupt Latch Aggregator

This block gathers interrupt events from a bank of audio-interface channels (32 by default) and a bank of parallel-interface channels (14 by default). It drives three interrupt lines: audio-high, audio-low and parallel. Each raw source is first passed through a synchroniser. A rising edge on a synchronised source then sets a sticky latch bit. A per-channel priority select steers every audio channel into one of two separately readable views, high or low. The parallel channels have a single view.

Software reaches the block through a simple register port. By default, reading a latch view clears the latched bits shown in that view. A bit that rises in the same cycle as the clearing read survives it. Any source may be marked level-type: such a source bypasses its latch, shows its live synchronised state, is untouched by reads, and drops only when its cause ends. A control bit switches the block into write-one-to-clear mode. In that mode reads are non-destructive and a written 1 clears the corresponding bit. Each interrupt line is the OR of its view ANDed with a per-bit enable mask.

Top module: `irq_agg`

## Requirements
- R1: A rising edge on a non-level raw source sets its latch bit. The bit is visible in the register views and on the interrupt lines three clock edges after the input rises. The edges are two synchroniser stages and one latch stage.
- R2: Priority register bit n (address 3) set to 1 puts audio channel n in the high view (address 0) and on `irq_aud_hi_o`. Set to 0, it puts the channel in the low view (address 1) and on `irq_aud_lo_o`.
- R3: A read of address 0 or address 1 returns the view on `reg_rdata_o` one cycle after the read strobe. With write-one-to-clear mode off, that read clears only the latched bits of the view that was read.
- R4: With write-one-to-clear mode off, a read of the parallel view (address 2) returns its bits and clears the parallel latch.
- R5: A source marked level-type (address 6 for audio, address 7 for parallel; 1 = level) shows its live synchronised state in its view. A read does not clear it. It drops when the input drops.
- R6: Control bit 0 (address 8) set to 1 enables write-one-to-clear mode. In this mode a read clears nothing, and a write to addresses 0 to 2 clears exactly the bits written as 1. With the mode off, writes to addresses 0 to 2 have no effect.
- R7: An edge whose latch-set cycle coincides with a clearing read of its view stays latched after that read.
- R8: `irq_aud_hi_o`, `irq_aud_lo_o` and `irq_par_o` are each the OR of their view ANDed with the enable mask. The audio mask is at address 4 and the parallel mask at address 5; 1 = enabled.
- R9: After reset all latches, masks, priority bits, level-type bits, the control bit and `reg_rdata_o` are 0, and all interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| aud_src_i | input | N_AUD | Raw audio-interface interrupt sources |
| par_src_i | input | N_PAR | Raw parallel-interface interrupt sources |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data, valid the cycle after the strobe |
| irq_aud_hi_o | output | 1 | Audio high-priority interrupt |
| irq_aud_lo_o | output | 1 | Audio low-priority interrupt |
| irq_par_o | output | 1 | Parallel interrupt |

## Verification
An input edge reaches a latch view and its interrupt line three clock edges after the input rises. A level-type source needs two edges. The bench drives inputs on the falling edge and waits four full cycles before it looks, so both paths have settled. Read data and the clearing it causes land on the edge that follows the strobe, and the bench samples them at the next falling edge. The same-cycle race is timed exactly: the read strobe is placed in the cycle where the synchronised edge is detected, so the read captures the view without the new bit and the following read must show it.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int REG_AW = 4;
    localparam int REG_DW = 32;

    typedef enum logic [REG_AW-1:0] {
        ADR_AUD_HI   = 4'd0,
        ADR_AUD_LO   = 4'd1,
        ADR_PAR      = 4'd2,
        ADR_PRIO     = 4'd3,
        ADR_AUD_MASK = 4'd4,
        ADR_PAR_MASK = 4'd5,
        ADR_AUD_LVL  = 4'd6,
        ADR_PAR_LVL  = 4'd7,
        ADR_CTRL     = 4'd8
    } reg_addr_e;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/irq_latch_bank.sv
module irq_latch_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] live_i,
    input  logic [W-1:0] lvl_type_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] lat_o,
    output logic [W-1:0] view_o
);

    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] lat;
    } bank_t;

    bank_t        st_d, st_q;
    logic [W-1:0] evt;

    always_comb begin
        evt       = live_i & ~st_q.prev & ~lvl_type_i;
        st_d.prev = live_i;
        // a fresh edge wins over a clear in the same cycle
        st_d.lat  = (st_q.lat & ~clr_i & ~lvl_type_i) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lat_o  = st_q.lat;
    assign view_o = (st_q.lat & ~lvl_type_i) | (live_i & lvl_type_i);

    // R1: every detected edge is held in the latch one cycle later
    a_r1_edge_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((st_q.lat & $past(evt)) == $past(evt)));

    // R7: an edge meeting a clear of the same bit is not lost
    a_r7_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt & clr_i) != '0) |=> ((st_q.lat & $past(evt & clr_i)) == $past(evt & clr_i)));

    // R5: a source that stays level-type never holds a latch bit
    a_r5_level_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.lat & lvl_type_i & $past(lvl_type_i)) == '0));

endmodule

// File: rtl/irq_agg.sv
module irq_agg
    import irq_agg_pkg::*;
#(
    parameter int N_AUD       = 32,
    parameter int N_PAR       = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_AUD-1:0]  aud_src_i,
    input  logic [N_PAR-1:0]  par_src_i,
    input  logic              reg_rd_i,
    input  logic              reg_wr_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [REG_DW-1:0] reg_wdata_i,
    output logic [REG_DW-1:0] reg_rdata_o,
    output logic              irq_aud_hi_o,
    output logic              irq_aud_lo_o,
    output logic              irq_par_o
);

    typedef struct packed {
        logic [N_AUD-1:0]  prio;
        logic [N_AUD-1:0]  aud_mask;
        logic [N_PAR-1:0]  par_mask;
        logic [N_AUD-1:0]  aud_lvl;
        logic [N_PAR-1:0]  par_lvl;
        logic              w1c;
        logic [REG_DW-1:0] rdata;
    } cfg_t;

    cfg_t             cfg_d, cfg_q;
    logic [N_AUD-1:0] aud_sync, aud_lat, aud_view, aud_clr;
    logic [N_PAR-1:0] par_sync, par_lat, par_view, par_clr;
    logic             rd_hi, rd_lo, rd_par, wr_hi, wr_lo, wr_par;

    irq_sync #(.W(N_AUD), .STAGES(SYNC_STAGES)) u_aud_sync (
        .clk(clk), .rst_n(rst_n), .async_i(aud_src_i), .sync_o(aud_sync));

    irq_sync #(.W(N_PAR), .STAGES(SYNC_STAGES)) u_par_sync (
        .clk(clk), .rst_n(rst_n), .async_i(par_src_i), .sync_o(par_sync));

    irq_latch_bank #(.W(N_AUD)) u_aud_bank (
        .clk(clk), .rst_n(rst_n), .live_i(aud_sync), .lvl_type_i(cfg_q.aud_lvl),
        .clr_i(aud_clr), .lat_o(aud_lat), .view_o(aud_view));

    irq_latch_bank #(.W(N_PAR)) u_par_bank (
        .clk(clk), .rst_n(rst_n), .live_i(par_sync), .lvl_type_i(cfg_q.par_lvl),
        .clr_i(par_clr), .lat_o(par_lat), .view_o(par_view));

    always_comb begin
        rd_hi  = reg_rd_i && (reg_addr_i == ADR_AUD_HI);
        rd_lo  = reg_rd_i && (reg_addr_i == ADR_AUD_LO);
        rd_par = reg_rd_i && (reg_addr_i == ADR_PAR);
        wr_hi  = reg_wr_i && (reg_addr_i == ADR_AUD_HI);
        wr_lo  = reg_wr_i && (reg_addr_i == ADR_AUD_LO);
        wr_par = reg_wr_i && (reg_addr_i == ADR_PAR);

        aud_clr = '0;
        par_clr = '0;
        if (cfg_q.w1c) begin
            if (wr_hi)  aud_clr = aud_clr | (reg_wdata_i[N_AUD-1:0] & cfg_q.prio);
            if (wr_lo)  aud_clr = aud_clr | (reg_wdata_i[N_AUD-1:0] & ~cfg_q.prio);
            if (wr_par) par_clr = reg_wdata_i[N_PAR-1:0];
        end else begin
            if (rd_hi)  aud_clr = aud_clr | cfg_q.prio;
            if (rd_lo)  aud_clr = aud_clr | ~cfg_q.prio;
            if (rd_par) par_clr = '1;
        end
    end

    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr_i) begin
            unique case (reg_addr_i)
                ADR_PRIO:     cfg_d.prio     = reg_wdata_i[N_AUD-1:0];
                ADR_AUD_MASK: cfg_d.aud_mask = reg_wdata_i[N_AUD-1:0];
                ADR_PAR_MASK: cfg_d.par_mask = reg_wdata_i[N_PAR-1:0];
                ADR_AUD_LVL:  cfg_d.aud_lvl  = reg_wdata_i[N_AUD-1:0];
                ADR_PAR_LVL:  cfg_d.par_lvl  = reg_wdata_i[N_PAR-1:0];
                ADR_CTRL:     cfg_d.w1c      = reg_wdata_i[0];
                default:      ;
            endcase
        end
        if (reg_rd_i) begin
            cfg_d.rdata = '0;
            unique case (reg_addr_i)
                ADR_AUD_HI:   cfg_d.rdata[N_AUD-1:0] = aud_view & cfg_q.prio;
                ADR_AUD_LO:   cfg_d.rdata[N_AUD-1:0] = aud_view & ~cfg_q.prio;
                ADR_PAR:      cfg_d.rdata[N_PAR-1:0] = par_view;
                ADR_PRIO:     cfg_d.rdata[N_AUD-1:0] = cfg_q.prio;
                ADR_AUD_MASK: cfg_d.rdata[N_AUD-1:0] = cfg_q.aud_mask;
                ADR_PAR_MASK: cfg_d.rdata[N_PAR-1:0] = cfg_q.par_mask;
                ADR_AUD_LVL:  cfg_d.rdata[N_AUD-1:0] = cfg_q.aud_lvl;
                ADR_PAR_LVL:  cfg_d.rdata[N_PAR-1:0] = cfg_q.par_lvl;
                ADR_CTRL:     cfg_d.rdata[0]         = cfg_q.w1c;
                default:      ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign reg_rdata_o  = cfg_q.rdata;
    assign irq_aud_hi_o = |(aud_view & cfg_q.prio & cfg_q.aud_mask);
    assign irq_aud_lo_o = |(aud_view & ~cfg_q.prio & cfg_q.aud_mask);
    assign irq_par_o    = |(par_view & cfg_q.par_mask);

    // R3: a high-view read leaves latched low-priority bits in place
    a_r3_hi_read_spares_low: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hi && !reg_wr_i) |=> (($past(aud_lat & ~cfg_q.prio) & ~aud_lat) == '0));

    // R6: in write-one-to-clear mode a read removes no latched bit
    a_r6_w1c_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && !reg_wr_i && cfg_q.w1c) |=>
        ((($past(aud_lat) & ~aud_lat) == '0) && (($past(par_lat) & ~par_lat) == '0)));

    // R8: a fully masked audio bank raises neither audio line
    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.aud_mask == '0) |-> (!irq_aud_hi_o && !irq_aud_lo_o));

endmodule

// File: tb/irq_agg_tb_top.sv
`timescale 1ns/1ps
module irq_agg_tb_top;

    localparam int NA = 32;
    localparam int NP = 14;
    localparam logic [31:0] PRIO = 32'hA5A5_0F0F;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NA-1:0] aud = '0;
    logic [NP-1:0] par = '0;
    logic          rd = 1'b0, wr = 1'b0;
    logic [3:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq_hi, irq_lo, irq_par;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    irq_agg #(.N_AUD(NA), .N_PAR(NP), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .aud_src_i(aud), .par_src_i(par),
        .reg_rd_i(rd), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_aud_hi_o(irq_hi), .irq_aud_lo_o(irq_lo),
        .irq_par_o(irq_par));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
        rd = 1'b1; addr = a;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic pulse_aud(input logic [NA-1:0] v);
        aud = v; tick(1); aud = '0; tick(4);
    endtask

    task automatic pulse_par(input logic [NP-1:0] v);
        par = v; tick(1); par = '0; tick(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] exp;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R9 reset state
        chk("R9 rdata", rdata, 32'h0);
        chk("R9 irq lines", {29'h0, irq_hi, irq_lo, irq_par}, 32'h0);
        for (int a = 0; a < 9; a++) begin
            rd_reg(a[3:0], d);
            chk("R9 register zero", d, 32'h0);
        end

        wr_reg(4'd3, PRIO);
        wr_reg(4'd4, 32'hFFFF_FFFF);
        wr_reg(4'd5, 32'h0000_3FFF);
        rd_reg(4'd3, d);
        chk("R2 priority readback", d, PRIO);

        // R1 R2 R3 R8: sweep every audio channel
        for (int ch = 0; ch < NA; ch++) begin
            pulse_aud(NA'(1) << ch);
            chk("R2 R8 irq steering", {30'h0, irq_hi, irq_lo}, PRIO[ch] ? 32'h2 : 32'h1);
            exp = 32'(1) << ch;
            rd_reg(4'd0, d);
            chk("R1 R2 R3 high view", d, PRIO[ch] ? exp : 32'h0);
            rd_reg(4'd1, d);
            chk("R1 R2 R3 low view", d, PRIO[ch] ? 32'h0 : exp);
            chk("R3 cleared lines", {30'h0, irq_hi, irq_lo}, 32'h0);
        end

        // R3: high read clears only high bits
        pulse_aud('1);
        rd_reg(4'd0, d);
        chk("R3 all high", d, PRIO);
        chk("R3 low line kept", {31'h0, irq_lo}, 32'h1);
        rd_reg(4'd1, d);
        chk("R3 low survives high read", d, ~PRIO);
        rd_reg(4'd0, d);
        chk("R3 high cleared", d, 32'h0);

        // R4 R8: sweep parallel channels
        for (int ch = 0; ch < NP; ch++) begin
            pulse_par(NP'(1) << ch);
            chk("R8 irq_par", {31'h0, irq_par}, 32'h1);
            rd_reg(4'd2, d);
            chk("R4 par view", d, 32'(1) << ch);
            rd_reg(4'd2, d);
            chk("R4 par cleared", d, 32'h0);
            chk("R4 irq_par low", {31'h0, irq_par}, 32'h0);
        end

        // R8: mask blocks line, latch still set
        wr_reg(4'd4, 32'h0);
        pulse_aud(NA'(1));
        chk("R8 masked hi line", {31'h0, irq_hi}, 32'h0);
        wr_reg(4'd4, 32'h0000_0001);
        chk("R8 unmasked hi line", {31'h0, irq_hi}, 32'h1);
        rd_reg(4'd0, d);
        chk("R8 latched while masked", d, 32'h1);
        wr_reg(4'd4, 32'hFFFF_FFFF);

        // R5: level-type sources
        wr_reg(4'd6, 32'h0000_0008);
        wr_reg(4'd7, 32'h0000_2000);
        aud[3] = 1'b1; par[13] = 1'b1;
        tick(4);
        chk("R5 level hi line", {31'h0, irq_hi}, 32'h1);
        rd_reg(4'd0, d);
        chk("R5 level shown", d, 32'h8);
        rd_reg(4'd0, d);
        chk("R5 level not cleared by read", d, 32'h8);
        rd_reg(4'd2, d);
        rd_reg(4'd2, d);
        chk("R5 par level not cleared", d, 32'h2000);
        aud[3] = 1'b0; par[13] = 1'b0;
        tick(4);
        rd_reg(4'd0, d);
        chk("R5 level drops", d, 32'h0);
        chk("R5 lines drop", {30'h0, irq_hi, irq_par}, 32'h0);
        wr_reg(4'd6, 32'h0);
        wr_reg(4'd7, 32'h0);

        // R6: write-one-to-clear mode
        wr_reg(4'd8, 32'h1);
        pulse_aud(NA'(32'h11));
        pulse_par(NP'(4));
        rd_reg(4'd0, d);
        rd_reg(4'd0, d);
        chk("R6 read keeps high", d, 32'h1);
        wr_reg(4'd0, 32'h0);
        rd_reg(4'd0, d);
        chk("R6 zero write keeps", d, 32'h1);
        wr_reg(4'd0, 32'h1);
        rd_reg(4'd0, d);
        chk("R6 one write clears", d, 32'h0);
        rd_reg(4'd1, d);
        chk("R6 low untouched", d, 32'h10);
        wr_reg(4'd1, 32'h10);
        rd_reg(4'd1, d);
        chk("R6 low cleared", d, 32'h0);
        rd_reg(4'd2, d);
        chk("R6 par kept", d, 32'h4);
        wr_reg(4'd2, 32'h4);
        rd_reg(4'd2, d);
        chk("R6 par cleared", d, 32'h0);
        wr_reg(4'd8, 32'h0);
        pulse_aud(NA'(1));
        wr_reg(4'd0, 32'h1);
        rd_reg(4'd0, d);
        chk("R6 write ignored in normal mode", d, 32'h1);

        // R7: edge lands on the clearing read edge
        rd_reg(4'd0, d);
        chk("R7 precondition empty", d, 32'h0);
        aud[1] = 1'b1;
        tick(2);
        rd_reg(4'd0, d);
        chk("R7 racing read misses bit", d, 32'h0);
        rd_reg(4'd0, d);
        chk("R7 event kept", d, 32'h2);
        aud[1] = 1'b0;
        tick(4);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule